// File: doc/BRIEF.md
# Half-Bridge Leg Gate Controller

This block is the digital control path for a single inverter leg. Two active-low commands, one for the upper switch and one for the lower switch, each pass through a glitch filter. The filter rejects short spikes and delays both edges of a valid pulse by the same amount, so the pulse keeps its width. The filtered requests then go through an interlock. The interlock never lets both gate enables be high together. It also holds every turn-on back until both enables have been low for a minimum dead time.

A shutdown input from the protection logic removes both enables on the next clock. After shutdown clears, neither enable can return until a fresh dead time has passed. A three-phase driver uses three instances. All timing is counted in clock cycles. `FLT_CYC` sets the filter length and `DT_CYC` sets the dead time; with a 100 MHz clock, 25 and 32 cycles give about 250 ns and 320 ns.

Top module: `half_bridge_ctrl`

## Requirements
- R1: A command is asserted when its input is low. `gate_hi` follows `hi_cmd_n` and `gate_lo` follows `lo_cmd_n`. An enable rises FLT_CYC+1 clocks after its input falls, provided the interlock and dead time allow it.
- R2: A level on a command input that lasts fewer than FLT_CYC clocks does not change the matching enable. This holds for low-going and high-going spikes alike.
- R3: A command pulse that lasts FLT_CYC or more clocks produces an enable pulse of exactly the same number of clocks.
- R4: An enable only rises after both enables have been low for at least DT_CYC consecutive clocks. If the opposite command is released and this command is asserted in the same cycle, the enable rises exactly DT_CYC clocks after the opposite enable falls.
- R5: If the commands themselves leave a gap longer than DT_CYC clocks, the turn-on is not delayed beyond the filter latency of R1.
- R6: `gate_hi` and `gate_lo` are never high in the same cycle.
- R7: While one enable is high and its command stays asserted, the enable stays high even when the opposite command is asserted. The later command is suppressed.
- R8: If both commands become valid together while both enables are low, only `gate_lo` is produced.
- R9: On the clock after `shutdown` is sampled high, both enables are low. They stay low until DT_CYC clocks after the last clock on which shutdown was sampled high.
- R10: A suppressed command does not take effect when the blocking enable drops. It still waits out the dead time, and it is dropped if it is released before the dead time ends.
- R11: While reset is active, both enables are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_cmd_n | input | 1 | Upper-switch command, active low |
| lo_cmd_n | input | 1 | Lower-switch command, active low |
| shutdown | input | 1 | Forces both enables off, active high |
| gate_hi | output | 1 | Upper-switch gate enable, active high |
| gate_lo | output | 1 | Lower-switch gate enable, active high |

## Verification
The bench builds the block with FLT_CYC = 4 and DT_CYC = 6. With these values, a spike one clock shorter than the filter, a pulse exactly as long as the filter, and the whole dead-time window each take only a few cycles to hit. Edge positions can therefore be counted clock by clock. The sizes are also far enough apart that a dead-time error cannot be mistaken for a filter-latency error. The first-come, in-phase and suppressed-command cases can then be driven into a state where the dead time has expired or is still running.

// File: rtl/half_bridge_ctrl.sv
module half_bridge_ctrl #(
  parameter int FLT_CYC = 25,
  parameter int DT_CYC  = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_cmd_n,
  input  logic lo_cmd_n,
  input  logic shutdown,
  output logic gate_hi,
  output logic gate_lo
);
  localparam int FW = $clog2(FLT_CYC + 1);
  localparam int GW = $clog2(DT_CYC + 1);
  localparam logic [FW-1:0] FLT_LAST = FW'(FLT_CYC - 1);
  localparam logic [GW-1:0] GAP_DONE = GW'(DT_CYC - 1);

  logic [1:0] raw_n, filt_n;
  logic hi_req, lo_req;
  logic [GW-1:0] gap;
  logic gap_ok, hi_nx, lo_nx;

  assign raw_n = {lo_cmd_n, hi_cmd_n};

  for (genvar c = 0; c < 2; c++) begin : g_flt
    logic [FW-1:0] run;
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        run <= '0;
        q   <= 1'b1;
      end else if (raw_n[c] == q) begin
        run <= '0;
      end else if (run == FLT_LAST) begin
        run <= '0;
        q   <= raw_n[c];
      end else begin
        run <= run + 1'b1;
      end
    end
    assign filt_n[c] = q;
  end

  assign hi_req = ~filt_n[0];
  assign lo_req = ~filt_n[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           gap <= '0;
    else if (shutdown | gate_hi | gate_lo) gap <= '0;
    else if (gap != GAP_DONE)             gap <= gap + 1'b1;
  end

  assign gap_ok = (gap == GAP_DONE);
  assign hi_nx  = !shutdown && hi_req && (gate_hi || (!gate_lo && gap_ok && !lo_req));
  assign lo_nx  = !shutdown && lo_req && (gate_lo || (!gate_hi && gap_ok));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
    end else begin
      gate_hi <= hi_nx;
      gate_lo <= lo_nx;
    end
  end
endmodule

module half_bridge_ctrl_chk #(
  parameter int DT_CYC = 32
) (
  input logic clk,
  input logic rst_n,
  input logic shutdown,
  input logic hi_cmd_n,
  input logic gate_hi,
  input logic gate_lo,
  input logic hi_req,
  input logic lo_req
);
  localparam int CW = $clog2(DT_CYC + 1);
  logic [CW-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           low_run <= '0;
    else if (shutdown | gate_hi | gate_lo) low_run <= '0;
    else if (low_run != CW'(DT_CYC))      low_run <= low_run + 1'b1;
  end

  // R6
  exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));

  // R9
  shutdown_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> (!gate_hi && !gate_lo));

  // R4
  dead_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_hi) || $rose(gate_lo)) |-> (low_run >= CW'(DT_CYC)));

  // R7
  hold_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_hi && hi_req && !shutdown) |=> gate_hi);

  // R10
  live_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_lo) |-> $past(lo_req));

  // R2
  filter_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hi_req) |-> ($past(hi_cmd_n) == !hi_req));
endmodule

bind half_bridge_ctrl half_bridge_ctrl_chk #(.DT_CYC(DT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .shutdown(shutdown), .hi_cmd_n(hi_cmd_n),
  .gate_hi(gate_hi), .gate_lo(gate_lo), .hi_req(hi_req), .lo_req(lo_req)
);

// File: tb/test_half_bridge_ctrl.sv
module test_half_bridge_ctrl;
  localparam int FLT = 4;
  localparam int DT  = 6;
  localparam int NV  = 10;
  // {hi_cmd_n, lo_cmd_n, expected gate_hi, expected gate_lo}
  localparam logic [3:0] VEC [NV] = '{
    4'b1100, 4'b0110, 4'b0010, 4'b1001, 4'b0001,
    4'b1100, 4'b0001, 4'b1100, 4'b1001, 4'b0110
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic hi_cmd_n = 1'b1, lo_cmd_n = 1'b1, shutdown = 1'b0;
  logic gate_hi, gate_lo;
  int checks = 0, errors = 0, both_on = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  half_bridge_ctrl #(.FLT_CYC(FLT), .DT_CYC(DT)) i_half_bridge_ctrl (
    .clk(clk), .rst_n(rst_n), .hi_cmd_n(hi_cmd_n), .lo_cmd_n(lo_cmd_n),
    .shutdown(shutdown), .gate_hi(gate_hi), .gate_lo(gate_lo));

  always @(negedge clk) if (rst_n && gate_hi && gate_lo) both_on++;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rise_at(input bit hi_side, output int idx);
    idx = -1;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if (idx < 0 && (hi_side ? gate_hi : gate_lo)) idx = i;
    end
  endtask

  task automatic pulse_width(input int w, output int width, output int first);
    width = 0; first = -1;
    hi_cmd_n = 1'b0;
    for (int i = 1; i <= w + 20; i++) begin
      @(negedge clk);
      if (gate_hi) begin width++; if (first < 0) first = i; end
      if (i == w) hi_cmd_n = 1'b1;
    end
  endtask

  initial begin
    int idx, w, f, seen, lo_fall, hi_rise, gap_low;
    cyc(3);
    chk("R11 reset gate_hi", gate_hi, 0);
    chk("R11 reset gate_lo", gate_lo, 0);
    rst_n = 1'b1;
    cyc(20);

    for (int v = 0; v < NV; v++) begin
      hi_cmd_n = VEC[v][3];
      lo_cmd_n = VEC[v][2];
      cyc(20);
      chk($sformatf("R1/R7/R8 step %0d gate_hi", v), gate_hi, VEC[v][1]);
      chk($sformatf("R1/R7/R8 step %0d gate_lo", v), gate_lo, VEC[v][0]);
    end
    hi_cmd_n = 1'b1; lo_cmd_n = 1'b1; cyc(20);

    // R2 low-going spike one clock short of the filter
    seen = 0; hi_cmd_n = 1'b0;
    for (int i = 0; i < FLT - 1; i++) begin @(negedge clk); seen += gate_hi; end
    hi_cmd_n = 1'b1;
    for (int i = 0; i < 12; i++) begin @(negedge clk); seen += gate_hi; end
    chk("R2 low spike rejected", seen, 0);

    // R2 high-going spike while on
    hi_cmd_n = 1'b0; cyc(20);
    seen = 0; hi_cmd_n = 1'b1;
    for (int i = 0; i < FLT - 1; i++) begin @(negedge clk); seen += !gate_hi; end
    hi_cmd_n = 1'b0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); seen += !gate_hi; end
    chk("R2 high spike rejected", seen, 0);
    hi_cmd_n = 1'b1; cyc(20);

    // R3 width preservation and R1 latency
    pulse_width(9, w, f);
    chk("R3 width 9", w, 9);
    chk("R1 turn-on latency", f, FLT + 1);
    cyc(10);
    pulse_width(FLT, w, f);
    chk("R3 width at filter length", w, FLT);
    cyc(10);

    // R4 zero external gap
    lo_cmd_n = 1'b0; cyc(20);
    lo_cmd_n = 1'b1; hi_cmd_n = 1'b0;
    lo_fall = -1; hi_rise = -1; gap_low = 0;
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      if (lo_fall < 0 && !gate_lo) lo_fall = i;
      if (hi_rise < 0 && gate_hi) hi_rise = i;
      if (lo_fall > 0 && hi_rise < 0 && !gate_lo && !gate_hi) gap_low++;
    end
    chk("R4 low cycles before turn-on", gap_low, DT);
    chk("R4 turn-on position", hi_rise, FLT + 1 + DT);
    hi_cmd_n = 1'b1; cyc(20);

    // R5 long external gap
    lo_cmd_n = 1'b0; cyc(20);
    lo_cmd_n = 1'b1; cyc(20);
    hi_cmd_n = 1'b0;
    rise_at(1'b1, idx);
    chk("R5 unmodified latency", idx, FLT + 1);

    // R7 then R10: suppressed low command waits dead time
    lo_cmd_n = 1'b0; cyc(20);
    chk("R7 first output held", gate_hi, 1);
    chk("R7 later command suppressed", gate_lo, 0);
    hi_cmd_n = 1'b1;
    rise_at(1'b0, idx);
    chk("R10 suppressed waits dead time", idx, FLT + 1 + DT);

    // R10 suppressed command released inside dead time
    lo_cmd_n = 1'b1; cyc(20);
    hi_cmd_n = 1'b0; cyc(20);
    lo_cmd_n = 1'b0; cyc(10);
    hi_cmd_n = 1'b1; cyc(3);
    lo_cmd_n = 1'b1;
    seen = 0;
    for (int i = 0; i < 25; i++) begin @(negedge clk); seen += gate_lo; end
    chk("R10 dropped request never fires", seen, 0);
    chk("R10 upper off", gate_hi, 0);

    // R9 shutdown
    hi_cmd_n = 1'b0; cyc(20);
    shutdown = 1'b1; cyc(1);
    chk("R9 off on next clock", gate_hi, 0);
    seen = 0;
    for (int i = 0; i < 4; i++) begin @(negedge clk); seen += gate_hi; end
    chk("R9 held off", seen, 0);
    shutdown = 1'b0;
    rise_at(1'b1, idx);
    chk("R9 fresh dead time after release", idx, DT);
    hi_cmd_n = 1'b1; cyc(10);

    chk("R6 never both on", both_on, 0);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule